// File: doc/BRIEF.md
# Sixteen-bit Arithmetic and Logic Unit with Carry Chaining

A purely combinational arithmetic and logic unit for the execute stage of a 16-bit stack processor. It receives a 6-bit command code, two 16-bit operands and the current carry and carry-enable flags. It returns a 16-bit result, the carry value for the next state, a strobe that says whether the carry register is to be written, and an arithmetic error that flags a division or remainder by zero.

Add and subtract take one extra unit of carry or borrow only when carry and carry-enable are both set. Add, subtract and multiply always produce a new carry, whatever the enable bits say. Every other command leaves the carry alone. Multiply, divide and remainder treat their operands as two's-complement numbers. The zero and negative flags are formed outside this block from its result.

Top module: `stack_alu`

## Requirements
- R1: Code 16 (0x10, add) gives result = (a + b + k) mod 2^16, where k = carry AND carry-enable. Carry-out is the 17th bit of that sum and the carry strobe is 1.
- R2: Code 17 (0x11, subtract) gives result = (a - b - k) mod 2^16, with k as in R1. Carry-out is 1 exactly when the unsigned value a is less than b + k, and the carry strobe is 1.
- R3: Code 18 (0x12, multiply) gives the low 16 bits of the signed product a*b. Carry-out is 1 exactly when the signed 32-bit product differs from the sign extension of its low half, and the carry strobe is 1.
- R4: Codes 19 (0x13, divide) and 20 (0x14, remainder) give the signed quotient truncated toward zero and the remainder carrying the dividend's sign. -32768 / -1 yields 0x8000.
- R5: Divide or remainder with b = 0 raises the error output, gives result 0x0000 and strobe 0. The error is 0 for every other case.
- R6: Codes 21 (0x15), 22 (0x16), 23 (0x17) and 24 (0x18) give a AND b, a OR b, a XOR b and NOT a.
- R7: Code 25 (0x19) gives 0xFF00 | a when a[7] is 1, and a & 0x00FF otherwise.
- R8: Code 26 (0x1A) rotates a left by one, code 27 (0x1B) rotates a right by one, and code 28 (0x1C) swaps the two bytes of a.
- R9: Code 29 (0x1D) shifts a right by one keeping bit 15, code 30 (0x1E) shifts a left by one filling in 0, and code 31 (0x1F) shifts a right by one filling in 0.
- R10: For every code other than 16, 17 and 18, the carry strobe is 0 and carry-out equals the carry input. Codes outside 16..31 give result 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cmd | input | 6 | command code |
| opa | input | 16 | first operand |
| opb | input | 16 | second operand |
| flag_c | input | 1 | current carry flag |
| flag_ce | input | 1 | current carry-enable flag |
| result | output | 16 | command output |
| carry_out | output | 1 | carry value for the next state |
| carry_we | output | 1 | carry register write strobe |
| div_zero | output | 1 | divide or remainder by zero |

## Verification
The bench aims at the carry-in gate: a unit that used carry alone would add one too many when carry-enable is clear. It checks that multiply clears a carry that was set. A unit using the unsigned product's upper half would report overflow for -3 * 5. It drives the most negative dividend over -1 and a negative divisor, where a unit truncating the wrong way or giving the remainder the wrong sign returns the wrong value. Logic commands are driven with carry set, and a unit that cleared or strobed the carry shows it at the ports.

// File: rtl/stack_alu.sv
module stack_alu #(
  parameter int W = 16
) (
  input  logic [5:0]   cmd,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         flag_c,
  input  logic         flag_ce,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         carry_we,
  output logic         div_zero
);
  localparam int P = 2 * W;
  localparam int H = W / 2;

  logic         cin;
  logic [W:0]   sum, dif;
  logic signed [P-1:0] prod;
  logic         mul_ovf, bz, qneg;
  logic [W-1:0] mag_a, mag_b, uq, ur, new_res;
  logic         new_cy, new_we, err;

  assign cin   = flag_c & flag_ce;
  assign sum   = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin};
  assign dif   = {1'b0, opa} - {1'b0, opb} - {{W{1'b0}}, cin};
  assign prod  = P'($signed(opa)) * P'($signed(opb));
  assign mul_ovf = prod[P-1:W] != {W{prod[W-1]}};

  assign bz    = opb == '0;
  assign mag_a = opa[W-1] ? -opa : opa;
  assign mag_b = bz ? {{(W-1){1'b0}}, 1'b1} : (opb[W-1] ? -opb : opb);
  assign uq    = mag_a / mag_b;
  assign ur    = mag_a % mag_b;
  assign qneg  = opa[W-1] ^ opb[W-1];

  always_comb begin
    new_res = '0;
    new_cy  = 1'b0;
    new_we  = 1'b0;
    err     = 1'b0;
    if (cmd[5:4] == 2'b01) begin
      case (cmd[3:0])
        4'h0: begin new_res = sum[W-1:0]; new_cy = sum[W]; new_we = 1'b1; end
        4'h1: begin new_res = dif[W-1:0]; new_cy = dif[W]; new_we = 1'b1; end
        4'h2: begin new_res = prod[W-1:0]; new_cy = mul_ovf; new_we = 1'b1; end
        4'h3: begin err = bz; new_res = bz ? '0 : (qneg ? -uq : uq); end
        4'h4: begin err = bz; new_res = bz ? '0 : (opa[W-1] ? -ur : ur); end
        4'h5: new_res = opa & opb;
        4'h6: new_res = opa | opb;
        4'h7: new_res = opa ^ opb;
        4'h8: new_res = ~opa;
        4'h9: new_res = {{(W-H){opa[H-1]}}, opa[H-1:0]};
        4'hA: new_res = {opa[W-2:0], opa[W-1]};
        4'hB: new_res = {opa[0], opa[W-1:1]};
        4'hC: new_res = {opa[H-1:0], opa[W-1:H]};
        4'hD: new_res = {opa[W-1], opa[W-1:1]};
        4'hE: new_res = {opa[W-2:0], 1'b0};
        default: new_res = {1'b0, opa[W-1:1]};
      endcase
    end
  end

  assign result    = new_res;
  assign carry_we  = new_we;
  assign carry_out = new_we ? new_cy : flag_c;
  assign div_zero  = err;
endmodule

module stack_alu_chk #(
  parameter int W = 16
) (
  input logic [5:0]   cmd,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         flag_c,
  input logic         flag_ce,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         carry_we,
  input logic         div_zero
);
  logic is_div, is_cy;
  assign is_div = (cmd == 6'd19) || (cmd == 6'd20);
  assign is_cy  = (cmd == 6'd16) || (cmd == 6'd17) || (cmd == 6'd18);

  always_comb begin
    if (!is_cy)
      a_r10_carry_hold: assert (!carry_we && carry_out == flag_c)
        else $error("R10 carry touched by cmd %0d", cmd);
    if (is_cy)
      a_r1_carry_strobe: assert (carry_we)
        else $error("R1 carry strobe missing for cmd %0d", cmd);
    if (is_div && opb == '0)
      a_r5_div_zero: assert (div_zero && result == '0 && !carry_we)
        else $error("R5 divide by zero not flagged");
    if (div_zero)
      a_r5_no_false_err: assert (is_div && opb == '0)
        else $error("R5 spurious error");
    if (cmd == 6'd26)
      a_r8_rol: assert (result[0] == opa[W-1] && result[W-1:1] == opa[W-2:0])
        else $error("R8 rotate left wrong");
    if (cmd == 6'd30)
      a_r9_lsl: assert (result[0] == 1'b0 && result[W-1:1] == opa[W-2:0])
        else $error("R9 shift left wrong");
  end
endmodule

bind stack_alu stack_alu_chk #(.W(W)) u_chk (.*);

// File: tb/test_stack_alu.sv
module test_stack_alu;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  cmd = '0;
  logic [15:0] opa = '0, opb = '0;
  logic        flag_c = 1'b0, flag_ce = 1'b0;
  logic [15:0] result;
  logic        carry_out, carry_we, div_zero;

  always #5 clk = ~clk;

  stack_alu i_stack_alu (.cmd(cmd), .opa(opa), .opb(opb), .flag_c(flag_c),
    .flag_ce(flag_ce), .result(result), .carry_out(carry_out),
    .carry_we(carry_we), .div_zero(div_zero));

  typedef struct {
    logic [15:0] res;
    logic cy, we, dz;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic drive(input logic [5:0] c, input logic [15:0] a, input logic [15:0] b,
                       input logic fc, input logic fce, input logic [15:0] er,
                       input logic ecy, input logic ewe, input logic edz, input string tag);
    exp_t e;
    @(negedge clk);
    cmd = c; opa = a; opb = b; flag_c = fc; flag_ce = fce;
    e.res = er; e.cy = ecy; e.we = ewe; e.dz = edz; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (result !== e.res || carry_out !== e.cy || carry_we !== e.we || div_zero !== e.dz) begin
        errors++;
        $display("FAIL %s: got res=%h cy=%b we=%b dz=%b, expected res=%h cy=%b we=%b dz=%b",
                 e.tag, result, carry_out, carry_we, div_zero, e.res, e.cy, e.we, e.dz);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(6'h10, 16'h0000, 16'h0000, 0, 0, 16'h0000, 0, 1, 0, "R1 reset-state zeros");
    drive(6'h10, 16'h0005, 16'h0007, 1, 0, 16'h000C, 0, 1, 0, "R1 add, C without CE");
    drive(6'h10, 16'hFFFF, 16'h0001, 0, 0, 16'h0000, 1, 1, 0, "R1 add carry out");
    drive(6'h10, 16'h7FFF, 16'h0000, 1, 1, 16'h8000, 0, 1, 0, "R1 add with carry in");
    drive(6'h11, 16'h0005, 16'h0007, 0, 0, 16'hFFFE, 1, 1, 0, "R2 sub borrow");
    drive(6'h11, 16'h000A, 16'h0003, 1, 1, 16'h0006, 0, 1, 0, "R2 sub with borrow in");
    drive(6'h11, 16'h0000, 16'h0000, 1, 1, 16'hFFFF, 1, 1, 0, "R2 sub borrow from carry");
    drive(6'h12, 16'd300,  16'd300,  0, 0, 16'h5F90, 1, 1, 0, "R3 mul overflow");
    drive(6'h12, 16'hFFFD, 16'h0005, 1, 1, 16'hFFF1, 0, 1, 0, "R3 mul signed clears carry");
    drive(6'h12, 16'h8000, 16'h0001, 0, 0, 16'h8000, 0, 1, 0, "R3 mul most negative fits");
    drive(6'h12, 16'h0100, 16'h0100, 0, 0, 16'h0000, 1, 1, 0, "R3 mul zero low half");
    drive(6'h13, 16'hFFF9, 16'h0002, 1, 0, 16'hFFFD, 1, 0, 0, "R4 div truncation");
    drive(6'h14, 16'hFFF9, 16'h0002, 0, 0, 16'hFFFF, 0, 0, 0, "R4 mod dividend sign");
    drive(6'h14, 16'h0007, 16'hFFFE, 0, 0, 16'h0001, 0, 0, 0, "R4 mod negative divisor");
    drive(6'h13, 16'h8000, 16'hFFFF, 0, 0, 16'h8000, 0, 0, 0, "R4 div most negative by -1");
    drive(6'h13, 16'h1234, 16'h0000, 1, 1, 16'h0000, 1, 0, 1, "R5 div by zero");
    drive(6'h14, 16'h1234, 16'h0000, 0, 0, 16'h0000, 0, 0, 1, "R5 mod by zero");
    drive(6'h15, 16'hF0F0, 16'hFF00, 1, 1, 16'hF000, 1, 0, 0, "R6 and");
    drive(6'h16, 16'hF0F0, 16'h0F00, 0, 0, 16'hFFF0, 0, 0, 0, "R6 or");
    drive(6'h17, 16'hF0F0, 16'hFF00, 0, 0, 16'h0FF0, 0, 0, 0, "R6 xor");
    drive(6'h18, 16'h00FF, 16'h1234, 1, 0, 16'hFF00, 1, 0, 0, "R6 not");
    drive(6'h19, 16'h1280, 16'h0000, 0, 0, 16'hFF80, 0, 0, 0, "R7 signext negative");
    drive(6'h19, 16'hAB7F, 16'h0000, 0, 0, 16'h007F, 0, 0, 0, "R7 signext positive");
    drive(6'h1A, 16'h8001, 16'h0000, 0, 0, 16'h0003, 0, 0, 0, "R8 rol");
    drive(6'h1B, 16'h8001, 16'h0000, 0, 0, 16'hC000, 0, 0, 0, "R8 ror");
    drive(6'h1C, 16'h1234, 16'h0000, 0, 0, 16'h3412, 0, 0, 0, "R8 bswap");
    drive(6'h1D, 16'h8002, 16'h0000, 0, 0, 16'hC001, 0, 0, 0, "R9 asr");
    drive(6'h1E, 16'h8001, 16'h0000, 0, 0, 16'h0002, 0, 0, 0, "R9 lsl");
    drive(6'h1F, 16'h8001, 16'h0000, 1, 1, 16'h4000, 1, 0, 0, "R9 lsr");
    drive(6'h05, 16'h1234, 16'h5678, 1, 1, 16'h0000, 1, 0, 0, "R10 code below range");
    drive(6'h20, 16'h1234, 16'h5678, 0, 1, 16'h0000, 0, 0, 0, "R10 code above range");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule